// File: doc/BRIEF.md
# Shared Buffer Ownership Monitor

This block guards one on-chip memory buffer that a processor and an encryption engine share. Each core has its own request port. Every request from either core is judged in the same cycle it is presented, and is either granted or denied. Only a granted request inside the buffer window reaches the single memory-side port. Reads return their data one cycle later, and a denied read returns zero.

The rights to the buffer are not a fixed address map. A one-bit ownership state, which is the policy, selects which core holds the buffer exclusively. After reset the processor holds it. The processor fills the buffer with plaintext and then writes its hand-over word, which passes the buffer to the engine. The engine overwrites the same buffer with ciphertext and writes its own hand-over word, which gives the buffer back. The monitor consumes the hand-over words itself, and they never reach memory. A saturating counter records every denied request.

Top module: `shared_buf_monitor`

## Requirements
- R1: After reset the processor owns the buffer and `viol_cnt` is 0.
- R2: A request from the owner to an address in the buffer window (default 0x00 to 0x1F) is granted in the same cycle. In that cycle `mem_en` is 1, and `mem_we`, `mem_wdata` and `mem_addr` (the address minus the window base) follow the request.
- R3: Every valid request from the core that does not own the buffer is denied. Its `*_deny` is 1 in that cycle and it drives nothing onto the memory port.
- R4: A processor write to address 0x80 while the processor owns the buffer is granted and is not forwarded to memory. The engine owns the buffer from the next cycle.
- R5: An engine write to address 0x81 while the engine owns the buffer is granted and is not forwarded to memory. The processor owns the buffer from the next cycle.
- R6: A request is denied and ownership stays unchanged in each of these cases: a hand-over write by the non-owner, a write by either core to the other core's hand-over word, or a read of either hand-over word.
- R7: Any address that is neither in the buffer window nor a hand-over word is denied, even for the owner.
- R8: One cycle after a granted buffer read, `*_rvalid` is 1 and `*_rdata` carries `mem_rdata`. In every other cycle `*_rdata` is 0, including the cycle after a denied read.
- R9: When both cores are valid in the same cycle, only the owner's request can be granted, and the memory port carries only the owner's access.
- R10: `viol_cnt` rises by the number of requests denied in a cycle (0, 1 or 2). It saturates at its maximum and clears only on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p_valid | input | 1 | Processor request valid |
| p_we | input | 1 | Processor write enable |
| p_addr | input | AW | Processor address |
| p_wdata | input | DW | Processor write data |
| p_gnt | output | 1 | Processor request granted (combinational) |
| p_deny | output | 1 | Processor request denied (combinational) |
| p_rvalid | output | 1 | Processor read data valid |
| p_rdata | output | DW | Processor read data, zero unless a granted read |
| e_valid | input | 1 | Engine request valid |
| e_we | input | 1 | Engine write enable |
| e_addr | input | AW | Engine address |
| e_wdata | input | DW | Engine write data |
| e_gnt | output | 1 | Engine request granted (combinational) |
| e_deny | output | 1 | Engine request denied (combinational) |
| e_rvalid | output | 1 | Engine read data valid |
| e_rdata | output | DW | Engine read data, zero unless a granted read |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | OW | Word offset inside the buffer |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after mem_en |
| viol_cnt | output | CW | Saturating count of denied requests |

## Verification
A hand-over write and a request from the other core can arrive in the same cycle. The bench provokes this by having the processor write its hand-over word while the engine writes into the buffer. The expected result is the processor granted, the engine denied and counted, and the memory port idle. The following vectors then show that the engine alone holds the buffer. A second overlap puts a processor buffer write beside an engine buffer read while the engine is owner, and only the engine's read may reach memory and return data.

// File: rtl/shared_buf_monitor.sv
module shared_buf_monitor #(
  parameter int AW        = 8,
  parameter int DW        = 32,
  parameter int BUF_BASE  = 0,
  parameter int BUF_WORDS = 32,
  parameter logic [AW-1:0] PT_ADDR = 8'h80,
  parameter logic [AW-1:0] CT_ADDR = 8'h81,
  parameter int CW        = 8,
  localparam int OW       = $clog2(BUF_WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          p_valid,
  input  logic          p_we,
  input  logic [AW-1:0] p_addr,
  input  logic [DW-1:0] p_wdata,
  output logic          p_gnt,
  output logic          p_deny,
  output logic          p_rvalid,
  output logic [DW-1:0] p_rdata,
  input  logic          e_valid,
  input  logic          e_we,
  input  logic [AW-1:0] e_addr,
  input  logic [DW-1:0] e_wdata,
  output logic          e_gnt,
  output logic          e_deny,
  output logic          e_rvalid,
  output logic [DW-1:0] e_rdata,
  output logic          mem_en,
  output logic          mem_we,
  output logic [OW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [CW-1:0] viol_cnt
);

  localparam logic [AW-1:0] BASE_A = AW'(BUF_BASE);
  localparam logic [AW-1:0] SPAN_A = AW'(BUF_WORDS);
  localparam logic [CW-1:0] CMAX   = {CW{1'b1}};

  logic eng_own;
  logic p_in, e_in, p_hand, e_hand, p_ok, e_ok;
  logic p_rd_q, e_rd_q;
  logic [AW-1:0] p_off, e_off;
  logic [CW:0] cnt_sum;

  assign p_off  = p_addr - BASE_A;
  assign e_off  = e_addr - BASE_A;
  assign p_in   = p_off < SPAN_A;
  assign e_in   = e_off < SPAN_A;
  assign p_hand = p_we && (p_addr == PT_ADDR);
  assign e_hand = e_we && (e_addr == CT_ADDR);

  assign p_ok   = !eng_own && (p_in || p_hand);
  assign e_ok   =  eng_own && (e_in || e_hand);

  assign p_gnt  = p_valid &&  p_ok;
  assign p_deny = p_valid && !p_ok;
  assign e_gnt  = e_valid &&  e_ok;
  assign e_deny = e_valid && !e_ok;

  assign mem_en    = (p_gnt && p_in) || (e_gnt && e_in);
  assign mem_we    = eng_own ? e_we : p_we;
  assign mem_addr  = eng_own ? OW'(e_off) : OW'(p_off);
  assign mem_wdata = eng_own ? e_wdata : p_wdata;

  assign p_rvalid = p_rd_q;
  assign e_rvalid = e_rd_q;
  assign p_rdata  = p_rd_q ? mem_rdata : '0;
  assign e_rdata  = e_rd_q ? mem_rdata : '0;

  assign cnt_sum = {1'b0, viol_cnt} + (CW+1)'(p_deny) + (CW+1)'(e_deny);

  always_ff @(posedge clk) begin
    if (rst) begin
      eng_own  <= 1'b0;
      p_rd_q   <= 1'b0;
      e_rd_q   <= 1'b0;
      viol_cnt <= '0;
    end else begin
      if (p_gnt && p_hand)      eng_own <= 1'b1;
      else if (e_gnt && e_hand) eng_own <= 1'b0;
      p_rd_q   <= p_gnt && p_in && !p_we;
      e_rd_q   <= e_gnt && e_in && !e_we;
      viol_cnt <= cnt_sum[CW] ? CMAX : cnt_sum[CW-1:0];
    end
  end

endmodule

module shared_buf_monitor_chk #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [AW-1:0] PT_ADDR = 8'h80,
  parameter logic [AW-1:0] CT_ADDR = 8'h81,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          eng_own,
  input logic          p_valid,
  input logic          p_we,
  input logic [AW-1:0] p_addr,
  input logic          p_gnt,
  input logic          p_deny,
  input logic [DW-1:0] p_rdata,
  input logic          e_valid,
  input logic          e_we,
  input logic [AW-1:0] e_addr,
  input logic          e_gnt,
  input logic          e_deny,
  input logic [DW-1:0] e_rdata,
  input logic          mem_en,
  input logic [CW-1:0] viol_cnt
);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (viol_cnt == '0 && !eng_own));

  a_r9_single_grant: assert property (@(posedge clk) disable iff (rst)
    !(p_gnt && e_gnt));

  a_r2_mem_needs_grant: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> (p_gnt || e_gnt));

  a_r3_decision_exclusive: assert property (@(posedge clk) disable iff (rst)
    (p_valid |-> (p_gnt != p_deny)) and (e_valid |-> (e_gnt != e_deny)));

  a_r4_handoff_to_engine: assert property (@(posedge clk) disable iff (rst)
    (p_gnt && p_we && p_addr == PT_ADDR) |=> eng_own);

  a_r5_handoff_to_cpu: assert property (@(posedge clk) disable iff (rst)
    (e_gnt && e_we && e_addr == CT_ADDR) |=> !eng_own);

  a_r6_owner_holds: assert property (@(posedge clk) disable iff (rst)
    (!(p_gnt && p_we && p_addr == PT_ADDR) && !(e_gnt && e_we && e_addr == CT_ADDR))
      |=> $stable(eng_own));

  a_r8_p_rdata_zero: assert property (@(posedge clk) disable iff (rst)
    !(p_gnt && !p_we) |=> (p_rdata == '0));

  a_r8_e_rdata_zero: assert property (@(posedge clk) disable iff (rst)
    !(e_gnt && !e_we) |=> (e_rdata == '0));

  a_r10_count_up: assert property (@(posedge clk) disable iff (rst)
    ((p_deny || e_deny) && viol_cnt != {CW{1'b1}}) |=> (viol_cnt > $past(viol_cnt)));

  a_r10_count_hold: assert property (@(posedge clk) disable iff (rst)
    !(p_deny || e_deny) |=> $stable(viol_cnt));

endmodule

bind shared_buf_monitor shared_buf_monitor_chk #(
  .AW(AW), .DW(DW), .PT_ADDR(PT_ADDR), .CT_ADDR(CT_ADDR), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .eng_own(eng_own),
  .p_valid(p_valid), .p_we(p_we), .p_addr(p_addr), .p_gnt(p_gnt),
  .p_deny(p_deny), .p_rdata(p_rdata),
  .e_valid(e_valid), .e_we(e_we), .e_addr(e_addr), .e_gnt(e_gnt),
  .e_deny(e_deny), .e_rdata(e_rdata),
  .mem_en(mem_en), .viol_cnt(viol_cnt)
);

// File: tb/shared_buf_monitor_test.sv
`timescale 1ns/1ps
module shared_buf_monitor_test;
  localparam int AW = 8, DW = 32, OW = 5, CW = 8, NV = 15;

  logic clk = 1'b0, rst = 1'b1;
  logic p_valid = 0, p_we = 0, e_valid = 0, e_we = 0;
  logic [AW-1:0] p_addr = '0, e_addr = '0;
  logic [DW-1:0] p_wdata = '0, e_wdata = '0, mem_rdata;
  logic p_gnt, p_deny, p_rvalid, e_gnt, e_deny, e_rvalid;
  logic [DW-1:0] p_rdata, e_rdata, mem_wdata;
  logic mem_en, mem_we;
  logic [OW-1:0] mem_addr;
  logic [CW-1:0] viol_cnt;

  int checks = 0, fails = 0;
  logic [DW-1:0] mem [32];
  logic [DW-1:0] shadow [32];

  always #5 clk = ~clk;

  shared_buf_monitor uut (.*);

  always @(posedge clk) if (mem_en) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  // {pv, pw, pa, ev, ew, ea, exp_p_gnt, exp_e_gnt}
  localparam logic [21:0] VEC [NV] = '{
    {1'b1,1'b1,8'h05, 1'b0,1'b0,8'h00, 1'b1,1'b0},  // R2 owner write
    {1'b0,1'b0,8'h00, 1'b1,1'b0,8'h05, 1'b0,1'b0},  // R3 non-owner read
    {1'b1,1'b1,8'h81, 1'b0,1'b0,8'h00, 1'b0,1'b0},  // R6 other's word
    {1'b0,1'b0,8'h00, 1'b1,1'b1,8'h81, 1'b0,1'b0},  // R6 non-owner hand-over
    {1'b1,1'b0,8'h80, 1'b0,1'b0,8'h00, 1'b0,1'b0},  // R6 read of word
    {1'b1,1'b1,8'h40, 1'b0,1'b0,8'h00, 1'b0,1'b0},  // R7 outside
    {1'b1,1'b1,8'h1F, 1'b0,1'b0,8'h00, 1'b1,1'b0},  // R2 last word
    {1'b1,1'b1,8'h20, 1'b0,1'b0,8'h00, 1'b0,1'b0},  // R7 one past end
    {1'b1,1'b1,8'h80, 1'b1,1'b1,8'h03, 1'b1,1'b0},  // R4 + R9 overlap
    {1'b0,1'b0,8'h00, 1'b1,1'b1,8'h05, 1'b0,1'b1},  // R4 engine owns
    {1'b1,1'b0,8'h05, 1'b0,1'b0,8'h00, 1'b0,1'b0},  // R3 cpu now blocked
    {1'b1,1'b1,8'h80, 1'b0,1'b0,8'h00, 1'b0,1'b0},  // R6 non-owner hand-over
    {1'b1,1'b1,8'h06, 1'b1,1'b0,8'h05, 1'b0,1'b1},  // R9 overlap
    {1'b0,1'b0,8'h00, 1'b1,1'b1,8'h81, 1'b0,1'b1},  // R5 give back
    {1'b1,1'b0,8'h05, 1'b0,1'b0,8'h00, 1'b1,1'b0}   // R5 cpu owns again
  };

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input bit pv, pw, input logic [AW-1:0] pa, input bit ev, ew, input logic [AW-1:0] ea);
    p_valid = pv; p_we = pw; p_addr = pa; p_wdata = {8'hA1, 16'h0, pa};
    e_valid = ev; e_we = ew; e_addr = ea; e_wdata = {8'hE2, 16'h0, ea};
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit prv, erv;
    logic [DW-1:0] prd, erd;
    prv = 0; erv = 0; prd = '0; erd = '0;
    for (int i = 0; i < 32; i++) begin mem[i] = '0; shadow[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk(viol_cnt == 0, "R1 count after reset", DW'(viol_cnt), 0);
    chk(!p_rvalid && !e_rvalid && p_rdata == 0, "R1 idle read path", DW'(p_rvalid), 0);

    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      bit xpm, xem, xen;
      v = VEC[i];
      @(negedge clk);
      chk(p_rvalid == prv && p_rdata == prd, "R8 cpu read return", p_rdata, prd);
      chk(e_rvalid == erv && e_rdata == erd, "R8 engine read return", e_rdata, erd);
      drive(v[21], v[20], v[19:12], v[11], v[10], v[9:2]);
      #1;
      chk(p_gnt == v[1] && p_deny == (v[21] && !v[1]), "R3 cpu decision", {p_gnt, p_deny}, {v[1], v[21] && !v[1]});
      chk(e_gnt == v[0] && e_deny == (v[11] && !v[0]), "R9 engine decision", {e_gnt, e_deny}, {v[0], v[11] && !v[0]});
      xpm = v[1] && v[19:12] < 8'h20;
      xem = v[0] && v[9:2] < 8'h20;
      xen = xpm || xem;
      chk(mem_en == xen, "R2 memory strobe", DW'(mem_en), DW'(xen));
      if (xpm) begin
        chk(mem_we == v[20] && mem_addr == v[16:12] && (!v[20] || mem_wdata == p_wdata),
            "R2 cpu memory access", {mem_we, mem_addr}, {v[20], v[16:12]});
        prd = v[20] ? '0 : shadow[v[16:12]];
        if (v[20]) shadow[v[16:12]] = p_wdata;
      end else prd = '0;
      if (xem) begin
        chk(mem_we == v[10] && mem_addr == v[6:2] && (!v[10] || mem_wdata == e_wdata),
            "R9 engine memory access", {mem_we, mem_addr}, {v[10], v[6:2]});
        erd = v[10] ? '0 : shadow[v[6:2]];
        if (v[10]) shadow[v[6:2]] = e_wdata;
      end else erd = '0;
      prv = xpm && !v[20];
      erv = xem && !v[10];
    end
    @(negedge clk);
    chk(p_rvalid == prv && p_rdata == prd, "R8 final cpu read", p_rdata, prd);
    drive(0, 0, 0, 0, 0, 0);
    #1;
    chk(viol_cnt == 10, "R10 denial count", DW'(viol_cnt), 10);

    // R10: saturation
    for (int k = 0; k < 250; k++) begin
      @(negedge clk); drive(0, 0, 0, 1, 0, 8'h02);
    end
    @(negedge clk); drive(0, 0, 0, 0, 0, 0);
    #1;
    chk(viol_cnt == 8'hFF, "R10 saturate", DW'(viol_cnt), 32'hFF);
    @(negedge clk); drive(1, 0, 8'h33, 1, 0, 8'h02);
    @(negedge clk); drive(0, 0, 0, 0, 0, 0);
    #1;
    chk(viol_cnt == 8'hFF, "R10 stays at max", DW'(viol_cnt), 32'hFF);

    // R4 then reset returns ownership (R1)
    @(negedge clk); drive(1, 1, 8'h80, 0, 0, 0);
    #1;
    chk(p_gnt && !mem_en, "R4 hand-over not forwarded", {p_gnt, mem_en}, 2'b10);
    @(negedge clk); drive(0, 0, 0, 1, 0, 8'h05);
    #1;
    chk(e_gnt, "R4 engine granted after hand-over", DW'(e_gnt), 1);
    @(negedge clk); drive(0, 0, 0, 0, 0, 0); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #1;
    chk(viol_cnt == 0, "R1 count cleared", DW'(viol_cnt), 0);
    drive(1, 0, 8'h05, 1, 0, 8'h05);
    #1;
    chk(p_gnt && e_deny, "R1 cpu owns after reset", {p_gnt, e_deny}, 2'b11);
    @(negedge clk); drive(0, 0, 0, 0, 0, 0);
    #1;
    chk(p_rvalid && p_rdata == 32'hE200_0005, "R8 data survives", p_rdata, 32'hE200_0005);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule